// File: doc/BRIEF.md
# Interrupt Blocking Window Monitor

This block sits next to a processor core and follows, cycle by cycle, whether the core could accept a maskable interrupt. It models the core's global enable bit and the saved copy of that bit. The disable and restore instructions move the bit into and out of the saved copy, and direct writes, non-maskable-enable writes and branch-delay-slot occupancy also change whether the core can be interrupted. Because it tracks the real bit values, a nested disable/restore pair keeps interrupts off until something actually sets the global enable again.

Every run of consecutive cycles in which interrupts are blocked is timed against a free-running 64-bit cycle counter. When a run is longer than a programmable threshold, the block queues a record of its first blocked cycle, its first unblocked cycle and its length. A small FIFO holds these records and hands them out through a valid/ready interface. A sticky flag notes any record that is lost because the FIFO is full.

Top module: `irq_block_monitor`

## Requirements
- R1: After synchronous reset: `gie_o`=1, `sgie_o`=0, `nmie_o`=1, `rpt_valid`=0, `overflow_o`=0, and the threshold is 500.
- R2: A disable strobe copies the current global enable into the saved bit and clears the global enable from the next cycle on.
- R3: A restore strobe loads the global enable from the saved bit and never forces it to 1. After nested pairs, interrupts stay blocked until a direct write sets the global enable.
- R4: A direct global-enable write sets the bit to the written data. In the same cycle it takes priority over restore, and restore takes priority over disable.
- R5: A cycle is blocked when the registered global enable is 0, when `bds_busy` is high in that same cycle, or when the registered NMI enable is 0. An NMI-enable write takes effect from the next cycle.
- R6: The cycle counter is 64-bit unsigned and is 0 in the first cycle after reset. A record's start is the number of the first blocked cycle, its end is the number of the first unblocked cycle, and its length is end minus start.
- R7: A record is queued only when its length is strictly greater than the threshold.
- R8: A threshold load applies to windows that close in a later cycle. A window closing in the same cycle as the load uses the old value.
- R9: Up to 4 records are held and delivered in order. `rpt_valid` and the record fields hold steady until `rpt_ready` is accepted.
- R10: A record queued while the FIFO holds 4 entries is dropped, and `overflow_o` then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_stb | input | 1 | Disable instruction executed this cycle |
| rest_stb | input | 1 | Restore instruction executed this cycle |
| gie_wr | input | 1 | Direct write to the global enable |
| gie_wdata | input | 1 | Value of the direct global enable write |
| nmie_wr | input | 1 | Write to the NMI enable |
| nmie_wdata | input | 1 | Value of the NMI enable write |
| bds_busy | input | 1 | A branch delay slot is pending this cycle |
| thr_we | input | 1 | Threshold load strobe |
| thr_wdata | input | 32 | Threshold in cycles |
| rpt_valid | output | 1 | Record available |
| rpt_ready | input | 1 | Consumer accepts the record |
| rpt_start | output | 64 | First blocked cycle |
| rpt_end | output | 64 | First unblocked cycle |
| rpt_len | output | 64 | Window length in cycles |
| gie_o | output | 1 | Modelled global enable |
| sgie_o | output | 1 | Modelled saved enable |
| nmie_o | output | 1 | Modelled NMI enable |
| overflow_o | output | 1 | Sticky record-dropped flag |

## Verification
The assertions assume that reset is applied before the first meaningful cycle, that the inputs carry clean 0/1 values, and that the 64-bit counter never wraps during a run. The stimulus drives all inputs on the falling edge and applies at most one enable-changing strobe per cycle. The one exception is the priority check, which applies two strobes together on purpose. Every window starts from a known enable state, so the expected start, end and length follow from the cycle in which each strobe was driven.

// File: rtl/irqmon_pkg.sv
package irqmon_pkg;
  localparam int CYC_W = 64;
  typedef logic [CYC_W-1:0] cyc_t;
  typedef struct packed {
    cyc_t start;
    cyc_t stop;
    cyc_t len;
  } rec_t;
endpackage

// File: rtl/irqmon_enable_model.sv
module irqmon_enable_model (
  input  logic clk,
  input  logic rst,
  input  logic dis_i,
  input  logic rest_i,
  input  logic gie_wr_i,
  input  logic gie_wd_i,
  input  logic nmie_wr_i,
  input  logic nmie_wd_i,
  input  logic bds_i,
  output logic gie_o,
  output logic sgie_o,
  output logic nmie_o,
  output logic blocked_o
);
  logic gie_q, sgie_q, nmie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b1;
      sgie_q <= 1'b0;
      nmie_q <= 1'b1;
    end else begin
      if (gie_wr_i) begin
        gie_q <= gie_wd_i;
      end else if (rest_i) begin
        gie_q <= sgie_q;
      end else if (dis_i) begin
        sgie_q <= gie_q;
        gie_q  <= 1'b0;
      end
      if (nmie_wr_i) nmie_q <= nmie_wd_i;
    end
  end

  assign blocked_o = !gie_q || bds_i || !nmie_q;
  assign gie_o  = gie_q;
  assign sgie_o = sgie_q;
  assign nmie_o = nmie_q;

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dis_i && !rest_i && !gie_wr_i |=> !gie_q); // R2
  AST_DIS_SAVES: assert property (@(posedge clk) disable iff (rst)
    dis_i && !rest_i && !gie_wr_i |=> sgie_q == $past(gie_q)); // R2
  AST_REST_LOADS: assert property (@(posedge clk) disable iff (rst)
    rest_i && !gie_wr_i |=> gie_q == $past(sgie_q)); // R3
  AST_GIE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dis_i && !rest_i && !gie_wr_i |=> $stable(gie_q)); // R4
endmodule

// File: rtl/irqmon_window.sv
module irqmon_window
  import irqmon_pkg::*;
#(
  parameter int THR_W   = 32,
  parameter int THR_RST = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blocked_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_wd_i,
  output logic             push_o,
  output rec_t             rec_o
);
  localparam int PAD_W = CYC_W - THR_W;

  cyc_t             cyc_q, start_q;
  logic             in_win_q;
  logic [THR_W-1:0] thr_q;
  cyc_t             len_w;
  cyc_t             thr_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q    <= '0;
      start_q  <= '0;
      in_win_q <= 1'b0;
      thr_q    <= THR_W'(THR_RST);
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (thr_we_i) thr_q <= thr_wd_i;
      if (blocked_i && !in_win_q) begin
        in_win_q <= 1'b1;
        start_q  <= cyc_q;
      end else if (!blocked_i && in_win_q) begin
        in_win_q <= 1'b0;
      end
    end
  end

  assign len_w   = cyc_q - start_q;
  assign thr_ext = {{PAD_W{1'b0}}, thr_q};
  assign push_o  = in_win_q && !blocked_i && (len_w > thr_ext);
  assign rec_o   = '{start: start_q, stop: cyc_q, len: len_w};

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc_q == $past(cyc_q) + 1'b1); // R6
  AST_WIN_OPENS: assert property (@(posedge clk) disable iff (rst)
    blocked_i |=> in_win_q); // R5
  AST_START_HELD: assert property (@(posedge clk) disable iff (rst)
    in_win_q && blocked_i |=> $stable(start_q)); // R6
endmodule

// File: rtl/irqmon_fifo.sv
module irqmon_fifo
  import irqmon_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  rec_t din_i,
  input  logic ready_i,
  output logic valid_o,
  output rec_t dout_o,
  output logic ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

  rec_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   count;
  logic             ovf_q;
  logic             full, wr_en, rd_en;

  assign full  = (count == FULL_CNT);
  assign wr_en = push_i && !full;
  assign rd_en = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign valid_o = (count != '0);
  assign dout_o  = mem[rd_ptr];
  assign ovf_o   = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q); // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ready_i |=> valid_o && $stable(dout_o)); // R9
endmodule

// File: rtl/irq_block_monitor.sv
module irq_block_monitor
  import irqmon_pkg::*;
#(
  parameter int THR_W   = 32,
  parameter int THR_RST = 500,
  parameter int DEPTH   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dis_stb,
  input  logic             rest_stb,
  input  logic             gie_wr,
  input  logic             gie_wdata,
  input  logic             nmie_wr,
  input  logic             nmie_wdata,
  input  logic             bds_busy,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_wdata,
  output logic             rpt_valid,
  input  logic             rpt_ready,
  output logic [CYC_W-1:0] rpt_start,
  output logic [CYC_W-1:0] rpt_end,
  output logic [CYC_W-1:0] rpt_len,
  output logic             gie_o,
  output logic             sgie_o,
  output logic             nmie_o,
  output logic             overflow_o
);
  logic blocked, push;
  rec_t rec_in, rec_out;

  irqmon_enable_model u_en (
    .clk(clk), .rst(rst), .dis_i(dis_stb), .rest_i(rest_stb),
    .gie_wr_i(gie_wr), .gie_wd_i(gie_wdata),
    .nmie_wr_i(nmie_wr), .nmie_wd_i(nmie_wdata), .bds_i(bds_busy),
    .gie_o(gie_o), .sgie_o(sgie_o), .nmie_o(nmie_o), .blocked_o(blocked)
  );

  irqmon_window #(.THR_W(THR_W), .THR_RST(THR_RST)) u_win (
    .clk(clk), .rst(rst), .blocked_i(blocked),
    .thr_we_i(thr_we), .thr_wd_i(thr_wdata),
    .push_o(push), .rec_o(rec_in)
  );

  irqmon_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(push), .din_i(rec_in),
    .ready_i(rpt_ready), .valid_o(rpt_valid), .dout_o(rec_out),
    .ovf_o(overflow_o)
  );

  assign rpt_start = rec_out.start;
  assign rpt_end   = rec_out.stop;
  assign rpt_len   = rec_out.len;

  AST_LEN_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> rpt_len == rpt_end - rpt_start); // R6
endmodule

// File: tb/irq_block_monitor_tb.sv
module irq_block_monitor_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dis_stb = 0, rest_stb = 0, gie_wr = 0, gie_wdata = 0;
  logic nmie_wr = 0, nmie_wdata = 0, bds_busy = 0, thr_we = 0;
  logic [31:0] thr_wdata = '0;
  logic rpt_ready = 0;
  logic rpt_valid, gie_o, sgie_o, nmie_o, overflow_o;
  logic [63:0] rpt_start, rpt_end, rpt_len;
  logic [63:0] tcyc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) tcyc <= rst ? 64'd0 : tcyc + 64'd1;

  irq_block_monitor u_dut (
    .clk(clk), .rst(rst), .dis_stb(dis_stb), .rest_stb(rest_stb),
    .gie_wr(gie_wr), .gie_wdata(gie_wdata), .nmie_wr(nmie_wr),
    .nmie_wdata(nmie_wdata), .bds_busy(bds_busy), .thr_we(thr_we),
    .thr_wdata(thr_wdata), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_start(rpt_start), .rpt_end(rpt_end), .rpt_len(rpt_len),
    .gie_o(gie_o), .sgie_o(sgie_o), .nmie_o(nmie_o), .overflow_o(overflow_o)
  );

  localparam int NV = 6;
  localparam logic [31:0] VT_THR [NV] = '{32'd10, 32'd10, 32'd0, 32'd100, 32'd2, 32'd40};
  localparam logic [31:0] VT_N   [NV] = '{32'd11, 32'd10, 32'd1, 32'd3, 32'd3, 32'd40};
  localparam bit          VT_EXP [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic load_thr(input logic [31:0] v);
    thr_we = 1; thr_wdata = v; step(); thr_we = 0;
  endtask

  // drive disable at c and restore at c+n; returns in close cycle c+n+1
  task automatic run_window(input int n, output logic [63:0] c);
    c = tcyc;
    dis_stb = 1; step(); dis_stb = 0;
    repeat (n-1) step();
    rest_stb = 1; step(); rest_stb = 0;
  endtask

  task automatic expect_rec(input string req, input logic [63:0] s,
                            input logic [63:0] e);
    int w = 0;
    while (!rpt_valid && w < 8) begin step(); w++; end
    chk({req, " valid"}, {63'd0, rpt_valid}, 64'd1);
    if (rpt_valid) begin
      chk({req, " start"}, rpt_start, s);
      chk({req, " end"}, rpt_end, e);
      chk({req, " len"}, rpt_len, e - s);
      rpt_ready = 1; step(); rpt_ready = 0;
    end
  endtask

  task automatic expect_none(input string req);
    logic seen = 0;
    repeat (6) begin step(); seen |= rpt_valid; end
    chk({req, " no record"}, {63'd0, seen}, 64'd0);
  endtask

  initial begin
    logic [63:0] c;
    logic [63:0] cs [5];
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 gie", {63'd0, gie_o}, 64'd1);
    chk("R1 sgie", {63'd0, sgie_o}, 64'd0);
    chk("R1 nmie", {63'd0, nmie_o}, 64'd1);
    chk("R1 valid", {63'd0, rpt_valid}, 64'd0);
    chk("R1 overflow", {63'd0, overflow_o}, 64'd0);
    // R1 R7 default threshold 500
    run_window(500, c); expect_none("R1 R7 len500");
    run_window(501, c); expect_rec("R1 R7 len501", c+1, c+502);

    // vector table walk: R7 strict comparison, R2 R6 timing
    for (int i = 0; i < NV; i++) begin
      load_thr(VT_THR[i]);
      step();
      run_window(int'(VT_N[i]), c);
      if (VT_EXP[i]) expect_rec("R7 R6 vector", c+1, c+1+VT_N[i]);
      else expect_none("R7 vector");
    end

    // R2 R3 nested pairs
    load_thr(0); step();
    c = tcyc;
    dis_stb = 1; step(); dis_stb = 0;
    chk("R2 sgie saved", {63'd0, sgie_o}, 64'd1);
    chk("R2 gie cleared", {63'd0, gie_o}, 64'd0);
    step();
    dis_stb = 1; step(); dis_stb = 0;
    chk("R2 inner saves 0", {63'd0, sgie_o}, 64'd0);
    step();
    rest_stb = 1; step(); rest_stb = 0;
    chk("R3 inner restore", {63'd0, gie_o}, 64'd0);
    step();
    rest_stb = 1; step(); rest_stb = 0;
    chk("R3 outer restore", {63'd0, gie_o}, 64'd0);
    chk("R3 no early record", {63'd0, rpt_valid}, 64'd0);
    step();
    gie_wr = 1; gie_wdata = 1; step(); gie_wr = 0;
    expect_rec("R3 nested window", c+1, c+9);

    // R4 direct write and priority
    c = tcyc;
    gie_wr = 1; gie_wdata = 0; step(); gie_wr = 0;
    step(); step();
    gie_wr = 1; gie_wdata = 1; step(); gie_wr = 0;
    expect_rec("R4 direct write", c+1, c+4);
    dis_stb = 1; gie_wr = 1; gie_wdata = 1; step(); dis_stb = 0; gie_wr = 0;
    chk("R4 write beats disable", {63'd0, gie_o}, 64'd1);
    expect_none("R4 priority");

    // R5 branch delay slot blocks combinationally
    c = tcyc;
    bds_busy = 1; repeat (4) step(); bds_busy = 0;
    expect_rec("R5 delay slot", c, c+4);

    // R5 NMI enable
    c = tcyc;
    nmie_wr = 1; nmie_wdata = 0; step(); nmie_wr = 0;
    chk("R5 nmie cleared", {63'd0, nmie_o}, 64'd0);
    step(); step();
    nmie_wr = 1; nmie_wdata = 1; step(); nmie_wr = 0;
    expect_rec("R5 nmi window", c+1, c+4);

    // R8 threshold load in the closing cycle uses the old value
    load_thr(100); step();
    run_window(5, c);
    thr_we = 1; thr_wdata = 3; step(); thr_we = 0;
    expect_none("R8 same-cycle load");
    run_window(5, c); expect_rec("R8 new threshold", c+1, c+6);

    // R9 R10 FIFO ordering and overflow
    load_thr(0); step();
    for (int k = 0; k < 5; k++) begin
      run_window(1, c); cs[k] = c; step(); step();
    end
    chk("R10 overflow set", {63'd0, overflow_o}, 64'd1);
    for (int k = 0; k < 4; k++) expect_rec("R9 order", cs[k]+1, cs[k]+2);
    step();
    chk("R10 fifth dropped", {63'd0, rpt_valid}, 64'd0);
    chk("R10 overflow sticky", {63'd0, overflow_o}, 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule